// File: doc/BRIEF.md
# Configurable GPIO Cell Datapath

This block models the fabric-facing logic of one general-purpose I/O cell. Toward the pad it takes a 4-bit output word and an output enable from the core. It drives one pad data bit and a tristate control. From the pad it samples the incoming bit and returns a 4-bit input word to the core. It also returns an alternate copy of the pad input that passes through no register. Each direction has its own pair of clocks: a slow word clock, and a fast clock running at four times that rate. The rising edges of the two clocks line up.

One of three operating modes is chosen at reset. Plain registered mode uses only bit 0 in each direction. Double data rate mode moves two bits per slow period, and bit 0 is the rising-edge bit. Serialize/deserialize mode moves four bits per slow period, and bit 0 is first on the wire. For differential use, a second enable input must match the main enable. The cell mirrors the registered enable onto a companion tristate output and reports any mismatch between the two enable inputs.

A slow period is split into four equal slots, numbered 0 to 3. Slot 0 begins at the rising slow edge. A 2-bit phase counter on each fast clock is cleared by the synchronous reset and keeps slot 0 aligned with the slow clock.

Top module: `gpio_cell`

## Requirements
- R1: While `rst` is high, the cell clears its state at each rising edge of both clocks. After the first slow edge in reset, `pad_o`, `pad_oe`, `pad_oe_b` and `en_mismatch` are 0 and `rx_word` is 0.
- R2: `mode_sel` is taken only at slow-clock edges while `rst` is high. The codes are 00 plain, 01 double data rate and 10 serdes. Code 11 acts as plain. Changes to `mode_sel` after reset has been released have no effect.
- R3: In plain mode, `pad_o` holds bit 0 of the `tx_word` sampled at the rising `out_clk` edge that starts the period. It holds that value for the whole period, and bits 3..1 are ignored.
- R4: In double data rate mode, `pad_o` carries bit 0 of the registered word during slots 0 and 1, the first half of the period. It carries bit 1 during slots 2 and 3, the second half.
- R5: In serdes mode, `pad_o` carries bit k of the registered word during slot k. Bit 0 goes out first and bit 3 last.
- R6: `pad_oe` equals the `tx_en` sampled at the rising `out_clk` edge that starts the period. The same edge also captures the output word. When `pad_oe` is 0, the pad is high-impedance.
- R7: `en_mismatch` is 1 for a period exactly when `tx_en` and `tx_en_pair` differed at the rising `out_clk` edge that started it. `pad_oe_b` always equals `pad_oe`.
- R8: In plain mode, `rx_word[0]` is the value of `pad_i` captured at the rising `in_clk` edge that ends period P, and bits 3..1 are 0. This value is visible after the next rising `in_clk` edge, that is, during period P+2.
- R9: In double data rate mode, `rx_word[0]` is the value of `pad_i` captured at the rising `in_clk` edge that ends period P. `rx_word[1]` is the value captured at the falling edge in the middle of period P, and bits 3..2 are 0. The word is visible during period P+2.
- R10: In serdes mode, `rx_word[k]` is the value of `pad_i` in slot k of period P, so the first bit received is on bit 0. The word is visible during period P+2.
- R11: `alt_in` follows `pad_i` within the same slot, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| out_clk | input | 1 | Slow clock of the output direction; registers the word and the enables |
| out_fclk | input | 1 | Fast output clock, four times `out_clk`, rising edges aligned |
| in_clk | input | 1 | Slow clock of the input direction; registers the input word |
| in_fclk | input | 1 | Fast input clock, four times `in_clk`, rising edges aligned |
| rst | input | 1 | Synchronous reset, active high, seen by all four clocks |
| mode_sel | input | 2 | Mode code, taken only during reset |
| tx_word | input | 4 | Output word from the core |
| tx_en | input | 1 | Output enable from the core |
| tx_en_pair | input | 1 | Complementary-leg enable; must equal `tx_en` |
| pad_o | output | 1 | Data bit driven toward the pad |
| pad_oe | output | 1 | Tristate control; 0 means high-impedance |
| pad_oe_b | output | 1 | Mirrored tristate control for the second leg of a pair |
| pad_i | input | 1 | Data bit received from the pad |
| alt_in | output | 1 | Unregistered copy of `pad_i` |
| rx_word | output | 4 | Input word to the core |
| en_mismatch | output | 1 | Registered flag: the two enables disagreed |

## Verification
Each mode is run for twenty periods. The output word steps through all sixteen values, so a swapped or stuck bit in any slot shows up. The pad sees sixteen different slot patterns, so each input slot can be told apart from the others. The enable pattern includes periods where the two enables disagree and periods where they agree with both polarities. This separates the enable path from the mismatch flag. One run latches double data rate and then moves `mode_sel` to serdes after reset; that run must still match the double data rate results. A separate run with code 11 must match plain mode.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;

   typedef enum logic [1:0] {
      CELL_SDR = 2'b00,
      CELL_DDR = 2'b01,
      CELL_SER = 2'b10,
      CELL_RSV = 2'b11
   } cell_mode_e;

   // the reserved code falls back to plain registered operation
   function automatic cell_mode_e cell_mode_decode(input logic [1:0] code);
      cell_mode_e m;
      case (code)
         2'b01:   m = CELL_DDR;
         2'b10:   m = CELL_SER;
         default: m = CELL_SDR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/gpio_phase_ctr.sv
module gpio_phase_ctr #(
   parameter int PH_W = 2
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PH_W-1:0] ph
);

   // wraps naturally at 2**PH_W, which equals the word width
   always_ff @(posedge clk) begin
      if (rst) ph <= '0;
      else     ph <= ph + 1'b1;
   end

endmodule

// File: rtl/gpio_tx_path.sv
module gpio_tx_path
   import gpio_cell_pkg::*;
#(
   parameter int WORD_W = 4
) (
   input  logic                      out_clk,
   input  logic                      out_fclk,
   input  logic                      rst,
   input  logic [1:0]                mode_sel,
   input  logic [WORD_W-1:0]         tx_word,
   input  logic                      tx_en,
   input  logic                      tx_en_pair,
   output logic                      pad_o,
   output logic                      oe_q,
   output logic                      mis_q,
   output logic [1:0]                mode_o,
   output logic [$clog2(WORD_W)-1:0] ph_o
);

   localparam int PH_W = $clog2(WORD_W);
   localparam int HALF = WORD_W / 2;

   cell_mode_e        mode_q;
   logic [WORD_W-1:0] word_q;
   logic [PH_W-1:0]   ph;

   // word, enable and mismatch share the slow output clock
   always_ff @(posedge out_clk) begin
      if (rst) begin
         mode_q <= cell_mode_decode(mode_sel);
         word_q <= '0;
         oe_q   <= 1'b0;
         mis_q  <= 1'b0;
      end else begin
         word_q <= tx_word;
         oe_q   <= tx_en;
         mis_q  <= tx_en ^ tx_en_pair;
      end
   end

   gpio_phase_ctr #(.PH_W(PH_W)) u_ph (
      .clk (out_fclk),
      .rst (rst),
      .ph  (ph)
   );

   always_comb begin
      case (mode_q)
         CELL_DDR: pad_o = (int'(ph) < HALF) ? word_q[0] : word_q[1];
         CELL_SER: pad_o = word_q[ph];
         default:  pad_o = word_q[0];
      endcase
   end

   assign mode_o = mode_q;
   assign ph_o   = ph;

endmodule

// File: rtl/gpio_rx_path.sv
module gpio_rx_path
   import gpio_cell_pkg::*;
#(
   parameter int WORD_W = 4
) (
   input  logic              in_clk,
   input  logic              in_fclk,
   input  logic              rst,
   input  logic [1:0]        mode_sel,
   input  logic              pad_i,
   output logic [WORD_W-1:0] rx_word
);

   localparam int          PH_W = $clog2(WORD_W);
   localparam int          HALF = WORD_W / 2;
   localparam [PH_W-1:0]   LAST = PH_W'(WORD_W - 1);

   cell_mode_e        mode_q;
   logic [PH_W-1:0]   ph;
   logic [WORD_W-1:0] slot_q;
   logic [WORD_W-1:0] asm_q;
   logic [WORD_W-1:0] rx_next;

   gpio_phase_ctr #(.PH_W(PH_W)) u_ph (
      .clk (in_fclk),
      .rst (rst),
      .ph  (ph)
   );

   // one pad sample per fast edge; the last sample closes the word
   always_ff @(posedge in_fclk) begin
      if (rst) begin
         slot_q <= '0;
         asm_q  <= '0;
      end else begin
         slot_q[ph] <= pad_i;
         if (ph == LAST) asm_q <= {pad_i, slot_q[WORD_W-2:0]};
      end
   end

   // rising-edge sample is the last slot, falling-edge sample ends the first half
   always_comb begin
      rx_next = '0;
      case (mode_q)
         CELL_DDR: begin
            rx_next[0] = asm_q[WORD_W-1];
            rx_next[1] = asm_q[HALF-1];
         end
         CELL_SER: rx_next = asm_q;
         default:  rx_next[0] = asm_q[WORD_W-1];
      endcase
   end

   always_ff @(posedge in_clk) begin
      if (rst) begin
         mode_q  <= cell_mode_decode(mode_sel);
         rx_word <= '0;
      end else begin
         rx_word <= rx_next;
      end
   end

endmodule

// File: rtl/gpio_cell.sv
module gpio_cell #(
   parameter int WORD_W  = 4,
   parameter bit DIFF_EN = 1'b1
) (
   input  logic              out_clk,
   input  logic              out_fclk,
   input  logic              in_clk,
   input  logic              in_fclk,
   input  logic              rst,
   input  logic [1:0]        mode_sel,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tx_en,
   input  logic              tx_en_pair,
   output logic              pad_o,
   output logic              pad_oe,
   output logic              pad_oe_b,
   input  logic              pad_i,
   output logic              alt_in,
   output logic [WORD_W-1:0] rx_word,
   output logic              en_mismatch
);

   localparam int PH_W = $clog2(WORD_W);

   generate
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
         $error("gpio_cell: WORD_W must be a power of two, at least 2");
      end
   endgenerate

   logic            oe_q;
   logic            mis_q;
   logic [1:0]      tx_mode_q;
   logic [PH_W-1:0] tx_ph;

   gpio_tx_path #(.WORD_W(WORD_W)) u_tx (
      .out_clk    (out_clk),
      .out_fclk   (out_fclk),
      .rst        (rst),
      .mode_sel   (mode_sel),
      .tx_word    (tx_word),
      .tx_en      (tx_en),
      .tx_en_pair (tx_en_pair),
      .pad_o      (pad_o),
      .oe_q       (oe_q),
      .mis_q      (mis_q),
      .mode_o     (tx_mode_q),
      .ph_o       (tx_ph)
   );

   gpio_rx_path #(.WORD_W(WORD_W)) u_rx (
      .in_clk   (in_clk),
      .in_fclk  (in_fclk),
      .rst      (rst),
      .mode_sel (mode_sel),
      .pad_i    (pad_i),
      .rx_word  (rx_word)
   );

   assign pad_oe = oe_q;
   assign alt_in = pad_i;

   generate
      if (DIFF_EN) begin : g_pair
         assign pad_oe_b    = oe_q;
         assign en_mismatch = mis_q;
      end else begin : g_single
         assign pad_oe_b    = 1'b0;
         assign en_mismatch = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/gpio_cell_chk.sv
module gpio_cell_chk #(
   parameter int WORD_W  = 4,
   parameter bit DIFF_EN = 1'b1
) (
   input logic                      out_clk,
   input logic                      out_fclk,
   input logic                      in_clk,
   input logic                      rst,
   input logic                      tx_en,
   input logic                      tx_en_pair,
   input logic                      pad_o,
   input logic                      pad_oe,
   input logic                      en_mismatch,
   input logic [WORD_W-1:0]         rx_word,
   input logic [1:0]                tx_mode,
   input logic [$clog2(WORD_W)-1:0] tx_ph
);

   // R1: reset leaves the output side idle
   a_r1_tx_idle: assert property (@(posedge out_clk)
      rst |=> (!pad_oe && !pad_o && !en_mismatch));

   // R1: reset clears the input word
   a_r1_rx_idle: assert property (@(posedge in_clk)
      rst |=> (rx_word == '0));

   // R2: the latched mode does not move once reset is released
   a_r2_mode_frozen: assert property (@(posedge out_clk) disable iff (rst)
      !rst |=> $stable(tx_mode));

   // R4: the first two slots of a double data rate period carry the same bit
   a_r4_ddr_half_hold: assert property (@(posedge out_fclk) disable iff (rst)
      (tx_mode == 2'b01 && tx_ph == '0) |=> (pad_o == $past(pad_o)));

   // R6: the tristate control follows the enable one slow edge later
   a_r6_oe_on: assert property (@(posedge out_clk) disable iff (rst)
      tx_en |=> pad_oe);
   a_r6_oe_off: assert property (@(posedge out_clk) disable iff (rst)
      !tx_en |=> !pad_oe);

   generate
      if (DIFF_EN) begin : g_pair_chk
         // R7: a disagreement raises the flag, agreement clears it
         a_r7_flag_set: assert property (@(posedge out_clk) disable iff (rst)
            (tx_en != tx_en_pair) |=> en_mismatch);
         a_r7_flag_clear: assert property (@(posedge out_clk) disable iff (rst)
            (tx_en == tx_en_pair) |=> !en_mismatch);
      end
   endgenerate

endmodule

bind gpio_cell gpio_cell_chk #(.WORD_W(WORD_W), .DIFF_EN(DIFF_EN)) u_chk (
   .out_clk     (out_clk),
   .out_fclk    (out_fclk),
   .in_clk      (in_clk),
   .rst         (rst),
   .tx_en       (tx_en),
   .tx_en_pair  (tx_en_pair),
   .pad_o       (pad_o),
   .pad_oe      (pad_oe),
   .en_mismatch (en_mismatch),
   .rx_word     (rx_word),
   .tx_mode     (tx_mode_q),
   .tx_ph       (tx_ph)
);

// File: tb/sim_gpio_cell.sv
module sim_gpio_cell;

   logic       fclk, sclk, rst;
   logic [1:0] mode_sel;
   logic [3:0] tx_word;
   logic       tx_en, tx_en_pair, pad_i;
   logic       pad_o, pad_oe, pad_oe_b, alt_in, en_mismatch;
   logic [3:0] rx_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [3:0] tw_h [0:31];
   logic [3:0] sl_h [0:31];
   logic       en_h [0:31];
   logic       pr_h [0:31];

   gpio_cell u0 (
      .out_clk     (sclk),
      .out_fclk    (fclk),
      .in_clk      (sclk),
      .in_fclk     (fclk),
      .rst         (rst),
      .mode_sel    (mode_sel),
      .tx_word     (tx_word),
      .tx_en       (tx_en),
      .tx_en_pair  (tx_en_pair),
      .pad_o       (pad_o),
      .pad_oe      (pad_oe),
      .pad_oe_b    (pad_oe_b),
      .pad_i       (pad_i),
      .alt_in      (alt_in),
      .rx_word     (rx_word),
      .en_mismatch (en_mismatch)
   );

   // fast clock 50 MHz, slow clock a quarter of it, rising edges aligned
   initial begin
      fclk = 0;
      forever #10 fclk = ~fclk;
   end
   initial begin
      sclk = 0;
      #30 sclk = 1;
      forever #40 sclk = ~sclk;
   end

   task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic exp_pad(input int eff, input logic [3:0] w, input int k);
      if (eff == 1) return (k < 2) ? w[0] : w[1];
      if (eff == 2) return w[k];
      return w[0];
   endfunction

   function automatic logic [3:0] exp_rx(input int eff, input logic [3:0] s);
      if (eff == 1) return {2'b00, s[1], s[3]};
      if (eff == 2) return s;
      return {3'b000, s[3]};
   endfunction

   // R1: hold reset with busy inputs, then release just after a slow edge
   task automatic do_reset(input logic [1:0] ms);
      rst = 1; mode_sel = ms;
      tx_word = 4'hF; tx_en = 1; tx_en_pair = 0; pad_i = 1;
      repeat (3) @(posedge sclk);
      #10;
      chk("R1 pad_o",      {3'b0, pad_o},       4'h0);
      chk("R1 pad_oe",     {3'b0, pad_oe},      4'h0);
      chk("R1 pad_oe_b",   {3'b0, pad_oe_b},    4'h0);
      chk("R1 mismatch",   {3'b0, en_mismatch}, 4'h0);
      chk("R1 rx_word",    rx_word,             4'h0);
      @(posedge sclk);
      #1 rst = 0;
   endtask

   task automatic run_mode(input logic [1:0] ms, input logic [1:0] ms_after,
                           input int eff, input string lbl);
      string tq, rq;
      tq = (eff == 0) ? "R3" : (eff == 1) ? "R4" : "R5";
      rq = (eff == 0) ? "R8" : (eff == 1) ? "R9" : "R10";
      do_reset(ms);
      mode_sel = ms_after;
      for (int p = 0; p < 20; p++) begin
         logic [3:0] s;
         tw_h[p] = 4'((p * 7 + int'(ms)) % 16);
         sl_h[p] = 4'((p * 11 + 5) % 16);
         en_h[p] = (p % 4 != 3);
         pr_h[p] = en_h[p] ^ (p % 5 == 2);
         s = sl_h[p];
         tx_word = tw_h[p]; tx_en = en_h[p]; tx_en_pair = pr_h[p];
         pad_i = s[0];
         for (int k = 0; k < 4; k++) begin
            if (k > 0) begin
               #11;
               pad_i = s[k];
            end
            #9;
            chk({tq, " pad_o ", lbl}, {3'b0, pad_o},
                {3'b0, (p >= 1) ? exp_pad(eff, tw_h[p-1], k) : 1'b0});
            chk({"R11 alt_in ", lbl}, {3'b0, alt_in}, {3'b0, s[k]});
            if (k == 0) begin
               chk({"R6 pad_oe ", lbl}, {3'b0, pad_oe},
                   {3'b0, (p >= 1) ? en_h[p-1] : 1'b0});
               chk({"R7 pad_oe_b ", lbl}, {3'b0, pad_oe_b},
                   {3'b0, (p >= 1) ? en_h[p-1] : 1'b0});
               chk({"R7 mismatch ", lbl}, {3'b0, en_mismatch},
                   {3'b0, (p >= 1) ? (en_h[p-1] ^ pr_h[p-1]) : 1'b0});
               chk({rq, " rx_word ", lbl}, rx_word,
                   (p >= 2) ? exp_rx(eff, sl_h[p-2]) : 4'h0);
            end
         end
         @(posedge sclk);
         #1;
      end
   endtask

   initial begin
      rst = 1; mode_sel = 0; tx_word = 0; tx_en = 0; tx_en_pair = 0; pad_i = 0;
      run_mode(2'b00, 2'b00, 0, "plain");
      run_mode(2'b01, 2'b01, 1, "ddr");
      run_mode(2'b10, 2'b10, 2, "serdes");
      run_mode(2'b11, 2'b11, 0, "R2 code11");
      run_mode(2'b01, 2'b10, 1, "R2 frozen");
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired got=0 exp=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule